// File: doc/BRIEF.md
# Chained Descriptor Transfer Engine

This block moves data between memory locations in response to peripheral events, without processor involvement. Each event source has an enable bit and a vector entry. The vector entry names the first descriptor of that source inside a small descriptor store held in the block. When an enabled source requests service, the engine loads the descriptor and reads one byte or word through its memory-master port. It writes that datum to the destination and then stores the descriptor back with updated addresses and count.

A descriptor may carry a chain flag. In that case the engine goes straight on to the descriptor at the next index within the same activation. Only the descriptor that ends a chain decides the outcome of the activation. That outcome is one of two things. Either a one-cycle clear pulse goes back to the requesting peripheral, or, when a normal-mode count is used up, the source is disabled and an interrupt pulse is raised while the peripheral flag is left alone.

Repeat mode suits circular tables. The count is split into a reload byte and a running byte. When the running byte runs out, the repeating side's address rewinds to where the table began.

Top module: `chx_engine`

## Requirements
- R1: After reset no memory access is made, all source enables read 0, and clear and interrupt outputs are 0.
- R2: A request from a source whose enable is 0 causes no memory access and leaves its descriptor unchanged.
- R3: Descriptor layout from the most significant bit: chain, source-increment, destination-increment, repeat, word-size, repeat-on-source, then source address (AW bits), destination address (AW bits), and a 16-bit count. Each descriptor does one read at the source address and then, in the next cycle, one write at the destination address. `mem_word_o` is 1 for word size. In byte size the written data is the low byte of the read data, zero-extended.
- R4: An incrementing address advances by 1 for byte size and by 2 for word size. A fixed address is kept. The updated descriptor is written back before the engine returns to idle.
- R5: In normal mode, when the decremented count is nonzero at the end of a chain, the engine pulses `clr_o` for the source for one cycle. The source's enable is kept.
- R6: In normal mode, when the decremented count is zero at the end of a chain, no clear is issued. The source's enable is cleared, and `irq_o` pulses for that source.
- R7: In repeat mode the count's upper byte is the reload value and its lower byte is the running counter. When the running counter reaches zero, it reloads from the upper byte, and the address on the repeating side (source if repeat-on-source is 1, else destination, when that side increments) returns to its start. Such an activation always ends with a clear and never with an interrupt.
- R8: A descriptor with chain set is followed, within the same activation, by the descriptor at the next index. Descriptors with chain set never produce a clear or an interrupt.
- R9: Among pending enabled requests, the lowest-numbered source is served first. Other requests wait until the running activation completes.
- R10: At most one bit of `clr_o` and `irq_o` taken together is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NSRC | Peripheral request flags |
| en_set_i | input | NSRC | Pulse to set source enables |
| en_o | output | NSRC | Current source enables |
| clr_o | output | NSRC | One-cycle flag clear to the peripheral |
| irq_o | output | NSRC | One-cycle end-of-transfer interrupt |
| vec_we_i | input | 1 | Vector entry write strobe |
| vec_src_i | input | SI_W | Source whose vector entry is written |
| vec_idx_i | input | DI_W | First descriptor index for that source |
| cfg_we_i | input | 1 | Descriptor write strobe |
| cfg_idx_i | input | DI_W | Descriptor index to write |
| cfg_wdata_i | input | DW | Descriptor value to write |
| rd_idx_i | input | DI_W | Descriptor index to read back |
| rd_desc_o | output | DW | Descriptor read back |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_word_o | output | 1 | Word (1) or byte (0) access |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid in the cycle of the read |

## Verification
Two things can coincide. One is a new request arriving. The other is the final write-back of an activation that is still running, which is also where that activation's clear or interrupt pulse and its enable update happen. The bench raises two sources' requests at the same edge, so the second waits through the whole first activation. The order is judged from the cycle in which each destination is written. The chained test confirms that the first half of a chain produces no clear or interrupt and that only the last descriptor reports the outcome.

// File: rtl/chx_pkg.sv
package chx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_READ,
      ST_WRITE,
      ST_BACK
   } chx_state_e;

   typedef struct packed {
      logic chain;
      logic src_inc;
      logic dst_inc;
      logic rpt;
      logic word;
      logic rep_src;
   } chx_mode_t;

   localparam int MODE_W = 6;
endpackage

// File: rtl/chx_prio.sv
module chx_prio #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
      any = |req;
   end
endmodule

// File: rtl/chx_desc_store.sv
module chx_desc_store #(
   parameter int DEPTH = 16,
   parameter int DW    = 54,
   parameter int IW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          a_we,
   input  logic [IW-1:0] a_idx,
   input  logic [DW-1:0] a_wdata,
   input  logic          b_we,
   input  logic [IW-1:0] b_idx,
   input  logic [DW-1:0] b_wdata,
   input  logic [IW-1:0] r0_idx,
   output logic [DW-1:0] r0_data,
   input  logic [IW-1:0] r1_idx,
   output logic [DW-1:0] r1_data
);
   logic [DW-1:0] ent [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   ent[g] <= '0;
         else if (a_we && a_idx == IW'(g))             ent[g] <= a_wdata;
         else if (b_we && b_idx == IW'(g))             ent[g] <= b_wdata;
      end
   end

   assign r0_data = ent[r0_idx];
   assign r1_data = ent[r1_idx];
endmodule

// File: rtl/chx_desc_next.sv
module chx_desc_next
   import chx_pkg::*;
#(
   parameter int AW    = 16,
   parameter int CNT_W = 16,
   parameter int DW    = MODE_W + 2 * AW + CNT_W
) (
   input  logic [DW-1:0] cur,
   output logic [DW-1:0] nxt,
   output logic          cnt_end
);
   localparam int HALF = CNT_W / 2;

   chx_mode_t        md;
   logic [AW-1:0]    sar, dar, sar_n, dar_n, step, rewind;
   logic [CNT_W-1:0] cnt, cnt_n;
   logic [HALF-1:0]  hi, run;

   always_comb begin
      md   = chx_mode_t'(cur[DW-1 -: MODE_W]);
      sar  = cur[CNT_W + AW +: AW];
      dar  = cur[CNT_W +: AW];
      cnt  = cur[CNT_W-1:0];
      hi   = cnt[CNT_W-1 -: HALF];
      run  = cnt[HALF-1:0] - 1'b1;
      step = md.word ? AW'(2) : AW'(1);
      rewind = md.word ? (AW'(hi) << 1) : AW'(hi);
      sar_n = md.src_inc ? sar + step : sar;
      dar_n = md.dst_inc ? dar + step : dar;
      cnt_end = 1'b0;
      if (md.rpt) begin
         if (run == '0) begin
            cnt_n = {hi, hi};
            if (md.rep_src && md.src_inc)   sar_n = sar_n - rewind;
            if (!md.rep_src && md.dst_inc)  dar_n = dar_n - rewind;
         end else begin
            cnt_n = {hi, run};
         end
      end else begin
         cnt_n   = cnt - 1'b1;
         cnt_end = (cnt_n == '0);
      end
      nxt = {cur[DW-1 -: MODE_W], sar_n, dar_n, cnt_n};
   end
endmodule

// File: rtl/chx_engine.sv
module chx_engine
   import chx_pkg::*;
#(
   parameter int NSRC  = 4,
   parameter int NDESC = 16,
   parameter int AW    = 16,
   parameter int CNT_W = 16,
   localparam int SI_W = (NSRC > 1) ? $clog2(NSRC) : 1,
   localparam int DI_W = (NDESC > 1) ? $clog2(NDESC) : 1,
   localparam int DW   = MODE_W + 2 * AW + CNT_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] req_i,
   input  logic [NSRC-1:0] en_set_i,
   output logic [NSRC-1:0] en_o,
   output logic [NSRC-1:0] clr_o,
   output logic [NSRC-1:0] irq_o,
   input  logic            vec_we_i,
   input  logic [SI_W-1:0] vec_src_i,
   input  logic [DI_W-1:0] vec_idx_i,
   input  logic            cfg_we_i,
   input  logic [DI_W-1:0] cfg_idx_i,
   input  logic [DW-1:0]   cfg_wdata_i,
   input  logic [DI_W-1:0] rd_idx_i,
   output logic [DW-1:0]   rd_desc_o,
   output logic            mem_req_o,
   output logic            mem_we_o,
   output logic            mem_word_o,
   output logic [AW-1:0]   mem_addr_o,
   output logic [15:0]     mem_wdata_o,
   input  logic [15:0]     mem_rdata_i
);
   if (NSRC < 1 || NSRC > 32) begin : g_bad_nsrc
      $error("chx_engine: NSRC out of range");
   end
   if (NDESC < 2) begin : g_bad_ndesc
      $error("chx_engine: NDESC must be at least 2");
   end
   if (CNT_W != 16) begin : g_bad_cnt
      $error("chx_engine: count must be two 8-bit halves");
   end

   chx_state_e      st_q;
   logic [SI_W-1:0] src_q, gnt_idx;
   logic            gnt_any;
   logic [DI_W-1:0] idx_q;
   logic [DW-1:0]   d_q, d_nxt, fetch_data;
   logic            cnt_end;
   logic [15:0]     data_q;
   logic [NSRC-1:0] en_q, src_hot, en_clr;
   logic [DI_W-1:0] vec_q [NSRC];
   chx_mode_t       md;
   logic            last_back;

   assign md        = chx_mode_t'(d_q[DW-1 -: MODE_W]);
   assign src_hot   = NSRC'(1) << src_q;
   assign last_back = (st_q == ST_BACK) && !md.chain;

   chx_prio #(.N(NSRC), .IW(SI_W)) u_prio (
      .req (req_i & en_q),
      .idx (gnt_idx),
      .any (gnt_any)
   );

   chx_desc_store #(.DEPTH(NDESC), .DW(DW), .IW(DI_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_we    (st_q == ST_BACK),
      .a_idx   (idx_q),
      .a_wdata (d_nxt),
      .b_we    (cfg_we_i),
      .b_idx   (cfg_idx_i),
      .b_wdata (cfg_wdata_i),
      .r0_idx  (idx_q),
      .r0_data (fetch_data),
      .r1_idx  (rd_idx_i),
      .r1_data (rd_desc_o)
   );

   chx_desc_next #(.AW(AW), .CNT_W(CNT_W), .DW(DW)) u_next (
      .cur     (d_q),
      .nxt     (d_nxt),
      .cnt_end (cnt_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NSRC; i++) vec_q[i] <= '0;
      end else if (vec_we_i) begin
         vec_q[vec_src_i] <= vec_idx_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         src_q  <= '0;
         idx_q  <= '0;
         d_q    <= '0;
         data_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (gnt_any) begin
               src_q <= gnt_idx;
               idx_q <= vec_q[gnt_idx];
               st_q  <= ST_FETCH;
            end
            ST_FETCH: begin
               d_q  <= fetch_data;
               st_q <= ST_READ;
            end
            ST_READ: begin
               data_q <= mem_rdata_i;
               st_q   <= ST_WRITE;
            end
            ST_WRITE: st_q <= ST_BACK;
            ST_BACK: begin
               if (md.chain) begin
                  idx_q <= idx_q + 1'b1;
                  st_q  <= ST_FETCH;
               end else begin
                  st_q  <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      en_clr = '0;
      clr_o  = '0;
      irq_o  = '0;
      if (last_back) begin
         if (!md.rpt && cnt_end) begin
            en_clr = src_hot;
            irq_o  = src_hot;
         end else begin
            clr_o  = src_hot;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= (en_q & ~en_clr) | en_set_i;
   end
   assign en_o = en_q;

   assign mem_req_o   = (st_q == ST_READ) || (st_q == ST_WRITE);
   assign mem_we_o    = (st_q == ST_WRITE);
   assign mem_word_o  = md.word;
   assign mem_addr_o  = (st_q == ST_WRITE) ? d_q[CNT_W +: AW] : d_q[CNT_W + AW +: AW];
   assign mem_wdata_o = md.word ? data_q : {8'h00, data_q[7:0]};
endmodule

// File: rtl/chx_engine_chk.sv
module chx_engine_chk #(
   parameter int NSRC = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            mem_req_o,
   input logic            mem_we_o,
   input logic [NSRC-1:0] clr_o,
   input logic [NSRC-1:0] irq_o,
   input logic [NSRC-1:0] en_o,
   input logic [NSRC-1:0] en_set_i
);
   assert_single_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_o | irq_o) && ((clr_o & irq_o) == '0));

   assert_write_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o) |-> $past(mem_req_o && !mem_we_o));

   assert_read_then_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_we_o) |=> (mem_req_o && mem_we_o));

   assert_end_disables_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((|irq_o) && (en_set_i == '0)) |=> ((en_o & $past(irq_o)) == '0));

   assert_clear_keeps_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((|clr_o) && (en_set_i == '0)) |=> (en_o == $past(en_o)));

   assert_outcome_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_o | irq_o) & ~en_o) == '0);
endmodule

bind chx_engine chx_engine_chk #(.NSRC(NSRC)) u_chx_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_req_o (mem_req_o),
   .mem_we_o  (mem_we_o),
   .clr_o     (clr_o),
   .irq_o     (irq_o),
   .en_o      (en_o),
   .en_set_i  (en_set_i)
);

// File: tb/chx_engine_test.sv
module chx_engine_test;
   localparam int CLK_PERIOD = 10;
   localparam int NSRC  = 4;
   localparam int NDESC = 16;
   localparam int AW    = 16;
   localparam int CNT_W = 16;
   localparam int SI_W  = 2;
   localparam int DI_W  = 4;
   localparam int DW    = 6 + 2 * AW + CNT_W;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] req = '0, en_set = '0;
   logic [NSRC-1:0] en_o, clr_o, irq_o;
   logic            vec_we = 1'b0;
   logic [SI_W-1:0] vec_src = '0;
   logic [DI_W-1:0] vec_idx = '0;
   logic            cfg_we = 1'b0;
   logic [DI_W-1:0] cfg_idx = '0;
   logic [DW-1:0]   cfg_wdata = '0;
   logic [DI_W-1:0] rd_idx = '0;
   logic [DW-1:0]   rd_desc;
   logic            mem_req, mem_we, mem_word;
   logic [AW-1:0]   mem_addr;
   logic [15:0]     mem_wdata, mem_rdata;

   logic [15:0] bmem [256];
   int          wr_cyc [256];
   int          wr_total = 0;
   int          cyc = 0;
   int          clr_cnt [NSRC];
   int          irq_cnt [NSRC];
   int          n_chk = 0, n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   chx_engine #(.NSRC(NSRC), .NDESC(NDESC), .AW(AW), .CNT_W(CNT_W)) uut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .en_set_i(en_set), .en_o(en_o),
      .clr_o(clr_o), .irq_o(irq_o), .vec_we_i(vec_we), .vec_src_i(vec_src),
      .vec_idx_i(vec_idx), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
      .cfg_wdata_i(cfg_wdata), .rd_idx_i(rd_idx), .rd_desc_o(rd_desc),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_word_o(mem_word),
      .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
   );

   assign mem_rdata = bmem[mem_addr[7:0]];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_req && mem_we) begin
         bmem[mem_addr[7:0]]   <= mem_wdata;
         wr_cyc[mem_addr[7:0]] <= cyc;
         wr_total              <= wr_total + 1;
      end
   end

   // peripheral model: the flag drops when the engine pulses clear
   always @(negedge clk) begin
      for (int i = 0; i < NSRC; i++) begin
         if (clr_o[i]) begin
            clr_cnt[i] = clr_cnt[i] + 1;
            req[i] = 1'b0;
         end
         if (irq_o[i]) irq_cnt[i] = irq_cnt[i] + 1;
      end
   end

   function automatic logic [DW-1:0] mk(input logic ch, si, di, rp, wd, rs,
                                        input logic [15:0] sa, da, ct);
      return {ch, si, di, rp, wd, rs, sa, da, ct};
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input logic ok, input string rq, input logic [63:0] act, exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   task automatic put_desc(input int idx, input logic [DW-1:0] d);
      cfg_we = 1'b1; cfg_idx = DI_W'(idx); cfg_wdata = d;
      tick(1);
      cfg_we = 1'b0;
   endtask

   task automatic put_vec(input int s, input int idx);
      vec_we = 1'b1; vec_src = SI_W'(s); vec_idx = DI_W'(idx);
      tick(1);
      vec_we = 1'b0;
   endtask

   task automatic enable(input int s);
      en_set = '0; en_set[s] = 1'b1;
      tick(1);
      en_set = '0;
   endtask

   task automatic fire(input int s);
      req[s] = 1'b1;
      tick(14);
   endtask

   function automatic logic [DW-1:0] peek(input int idx);
      rd_idx = DI_W'(idx);
      return rd_desc;
   endfunction

   task automatic look(input int idx, output logic [DW-1:0] d);
      rd_idx = DI_W'(idx);
      #1 d = rd_desc;
   endtask

   task automatic t_reset;
      check(mem_req == 1'b0, "R1 mem_req", 64'(mem_req), 0);
      check(en_o == '0, "R1 enables", 64'(en_o), 0);
      check(clr_o == '0, "R1 clr", 64'(clr_o), 0);
      check(irq_o == '0, "R1 irq", 64'(irq_o), 0);
   endtask

   task automatic t_disabled;
      logic [DW-1:0] d, e;
      int w0;
      e = mk(0, 1, 1, 0, 1, 0, 16'h0010, 16'h0070, 16'd7);
      put_desc(0, e);
      put_vec(0, 0);
      w0 = wr_total;
      fire(0);
      check(wr_total == w0, "R2 no write", 64'(wr_total), 64'(w0));
      look(0, d);
      check(d == e, "R2 desc kept", 64'(d), 64'(e));
      req[0] = 1'b0;
   endtask

   task automatic t_word_normal;
      logic [DW-1:0] d, e;
      bmem[8'h10] = 16'hA5C3;
      put_desc(2, mk(0, 1, 0, 0, 1, 0, 16'h0010, 16'h0080, 16'd3));
      put_vec(1, 2);
      enable(1);
      fire(1);
      check(bmem[8'h80] == 16'hA5C3, "R3 word data", 64'(bmem[8'h80]), 64'hA5C3);
      look(2, d);
      e = mk(0, 1, 0, 0, 1, 0, 16'h0012, 16'h0080, 16'd2);
      check(d == e, "R4 word update", 64'(d), 64'(e));
      check(clr_cnt[1] == 1, "R5 clear pulse", 64'(clr_cnt[1]), 1);
      check(en_o[1] == 1'b1, "R5 enable kept", 64'(en_o[1]), 1);
      check(irq_cnt[1] == 0, "R5 no irq", 64'(irq_cnt[1]), 0);
   endtask

   task automatic t_byte;
      logic [DW-1:0] d, e;
      bmem[8'h20] = 16'h1234;
      bmem[8'h90] = 16'hFFFF;
      put_desc(3, mk(0, 0, 1, 0, 0, 0, 16'h0020, 16'h0090, 16'd5));
      put_vec(2, 3);
      enable(2);
      fire(2);
      check(bmem[8'h90] == 16'h0034, "R3 byte data", 64'(bmem[8'h90]), 64'h34);
      look(3, d);
      e = mk(0, 0, 1, 0, 0, 0, 16'h0020, 16'h0091, 16'd4);
      check(d == e, "R4 byte update", 64'(d), 64'(e));
      check(clr_cnt[2] == 1, "R5 byte clear", 64'(clr_cnt[2]), 1);
   endtask

   task automatic t_normal_end;
      logic [DW-1:0] d;
      int w0;
      bmem[8'h30] = 16'h5A5A;
      put_desc(4, mk(0, 1, 1, 0, 1, 0, 16'h0030, 16'h00C0, 16'd1));
      put_vec(3, 4);
      enable(3);
      fire(3);
      check(bmem[8'hC0] == 16'h5A5A, "R6 last data", 64'(bmem[8'hC0]), 64'h5A5A);
      check(irq_cnt[3] == 1, "R6 irq", 64'(irq_cnt[3]), 1);
      check(clr_cnt[3] == 0, "R6 no clear", 64'(clr_cnt[3]), 0);
      check(en_o[3] == 1'b0, "R6 disabled", 64'(en_o[3]), 0);
      look(4, d);
      check(d[15:0] == 16'd0, "R6 count zero", 64'(d[15:0]), 0);
      w0 = wr_total;
      tick(12);
      check(wr_total == w0 && req[3], "R6 held flag idle", 64'(wr_total), 64'(w0));
      req[3] = 1'b0;
   endtask

   task automatic t_repeat;
      logic [DW-1:0] d, e;
      bmem[8'h40] = 16'h1111;
      bmem[8'h42] = 16'h2222;
      put_desc(5, mk(0, 1, 0, 1, 1, 1, 16'h0040, 16'h00D0, 16'h0202));
      put_vec(0, 5);
      enable(0);
      fire(0);
      look(5, d);
      e = mk(0, 1, 0, 1, 1, 1, 16'h0042, 16'h00D0, 16'h0201);
      check(d == e, "R7 first step", 64'(d), 64'(e));
      fire(0);
      check(bmem[8'hD0] == 16'h2222, "R7 second data", 64'(bmem[8'hD0]), 64'h2222);
      look(5, d);
      e = mk(0, 1, 0, 1, 1, 1, 16'h0040, 16'h00D0, 16'h0202);
      check(d == e, "R7 reload and rewind", 64'(d), 64'(e));
      fire(0);
      check(bmem[8'hD0] == 16'h1111, "R7 wrapped data", 64'(bmem[8'hD0]), 64'h1111);
      check(clr_cnt[0] == 3 && irq_cnt[0] == 0, "R7 clears only",
            64'(clr_cnt[0]), 3);
      check(en_o[0] == 1'b1, "R7 enable kept", 64'(en_o[0]), 1);
   endtask

   task automatic t_chain;
      logic [DW-1:0] d, e;
      int c0;
      bmem[8'h50] = 16'hBEEF;
      bmem[8'h52] = 16'h0BAD;
      bmem[8'h60] = 16'hCAFE;
      bmem[8'h62] = 16'hF00D;
      put_desc(8, mk(1, 1, 0, 1, 1, 1, 16'h0050, 16'h00A0, 16'h0404));
      put_desc(9, mk(0, 1, 0, 0, 1, 0, 16'h0060, 16'h00A2, 16'd2));
      put_vec(1, 8);
      c0 = clr_cnt[1];
      fire(1);
      check(bmem[8'hA0] == 16'hBEEF && bmem[8'hA2] == 16'hCAFE, "R8 both halves",
            64'({bmem[8'hA0], bmem[8'hA2]}), 64'hBEEFCAFE);
      check(clr_cnt[1] == c0 + 1, "R8 one clear", 64'(clr_cnt[1]), 64'(c0 + 1));
      look(8, d);
      e = mk(1, 1, 0, 1, 1, 1, 16'h0052, 16'h00A0, 16'h0403);
      check(d == e, "R8 first half written back", 64'(d), 64'(e));
      fire(1);
      check(irq_cnt[1] == 1 && clr_cnt[1] == c0 + 1, "R8 end only at tail",
            64'(irq_cnt[1]), 1);
      check(en_o[1] == 1'b0, "R8 tail disables", 64'(en_o[1]), 0);
      req[1] = 1'b0;
   endtask

   task automatic t_priority;
      put_desc(10, mk(0, 0, 0, 0, 1, 0, 16'h0070, 16'h00B0, 16'd5));
      put_desc(11, mk(0, 0, 0, 0, 1, 0, 16'h0072, 16'h00B2, 16'd5));
      bmem[8'h70] = 16'h7070;
      bmem[8'h72] = 16'h7272;
      put_vec(2, 10);
      put_vec(3, 11);
      enable(3);
      req[3] = 1'b1;
      req[2] = 1'b1;
      tick(20);
      check(bmem[8'hB0] == 16'h7070 && bmem[8'hB2] == 16'h7272, "R9 both served",
            64'({bmem[8'hB0], bmem[8'hB2]}), 64'h70707272);
      check(wr_cyc[8'hB0] < wr_cyc[8'hB2], "R9 lowest first",
            64'(wr_cyc[8'hB0]), 64'(wr_cyc[8'hB2]));
      check(wr_cyc[8'hB2] - wr_cyc[8'hB0] >= 5, "R9 second waits",
            64'(wr_cyc[8'hB2] - wr_cyc[8'hB0]), 5);
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         bmem[i] = 16'(i);
         wr_cyc[i] = 0;
      end
      for (int i = 0; i < NSRC; i++) begin
         clr_cnt[i] = 0;
         irq_cnt[i] = 0;
      end
      tick(3);
      t_reset();
      rst_n = 1'b1;
      tick(2);
      t_disabled();
      t_word_normal();
      t_byte();
      t_normal_end();
      t_repeat();
      t_chain();
      t_priority();
      report();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end
endmodule